// File: doc/BRIEF.md
# Reloadable Up/Down Timer with Capture and Baud Strobe

This block is a 16-bit timer/counter with three ways of working. In reload mode it counts up and, when it wraps, restarts from a stored reload value. An extra up/down option lets the level of a trigger pin set the counting direction. In capture mode it counts freely, and a falling edge on the trigger pin copies the running count into the reload register. In baud mode it counts at the fast rate of the state clock and emits a one-cycle strobe at each wrap, which a serial port can use as its bit clock.

The count source is either a machine-cycle enable or the falling edges of an external count pin. The external count pin and the trigger pin are both assumed to be synchronised already. Both pins are sampled in cycles where the machine-cycle enable is high. Software loads the count and reload bytes, the control byte and the mode byte through a simple byte-write port. Software clears the two event flags by writing the control byte.

Top module: `t2_reload_capture`

## Requirements
- R1: After a synchronous reset, count_q, reload_q, ovf_flag, trig_flag and baud_tick are all zero.
- R2: The write map is as follows. Address 0 holds the count low byte, 1 the count high byte, 2 the reload low byte, 3 the reload high byte, 4 the control byte and 5 the mode byte. A written count or reload byte appears on count_q or reload_q in the next cycle, and it wins over any hardware update of that byte in the same cycle. In the control byte, bit 0 is run, bit 1 selects the external count pin, bit 2 selects capture, bit 3 enables the trigger, bit 4 selects baud mode, bit 5 is the overflow flag value and bit 6 is the trigger flag value. In the mode byte, bit 0 enables up/down counting.
- R3: With run set and the external pin not selected (and not in baud mode), the count advances by one in each cycle where mc_en is high, and holds in all other cycles.
- R4: With the external pin selected, the count advances by one in each cycle where mc_en is high, ext_count_in is 0 and the previous mc_en sample of ext_count_in was 1.
- R5: While run is clear, the count does not change except through register writes and trigger-pin loads.
- R6: In reload mode with up/down disabled, a count step from FFFFh loads the reload value and sets ovf_flag.
- R7: In reload mode with up/down disabled and the trigger enabled, a trigger falling edge (sampled like R4) loads the reload value and sets trig_flag. A count step in the same cycle is dropped. With the trigger disabled, the edge has no effect.
- R8: With up/down enabled in reload mode, steps go upward while trig_in is 1, with the wrap handling of R6. Steps go downward while trig_in is 0. A downward step taken while the count equals the reload value loads FFFFh and sets ovf_flag.
- R9: With up/down enabled in reload mode, trigger edges neither load the count nor set trig_flag.
- R10: In capture mode, a trigger edge with the trigger enabled copies the pre-step count into reload_q and sets trig_flag. The count keeps stepping upward, and a step from FFFFh gives 0000h and sets ovf_flag.
- R11: In baud mode, each state-clock cycle is a count step unless the external pin is selected. A step from FFFFh loads the reload value and raises baud_tick for exactly the next cycle, and it never sets ovf_flag. An enabled trigger edge sets trig_flag only.
- R12: A control-byte write loads ovf_flag and trig_flag from bits 5 and 6. A hardware set of a flag in the same cycle takes priority over that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock, one cycle per count step in baud mode |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register byte write strobe |
| wr_addr | input | 3 | Register byte address |
| wr_data | input | 8 | Register byte value |
| mc_en | input | 1 | Machine-cycle enable, also the pin sampling strobe |
| ext_count_in | input | 1 | Synchronised external count pin |
| trig_in | input | 1 | Synchronised trigger pin (edge and direction level) |
| count_q | output | 16 | Current count |
| reload_q | output | 16 | Reload / capture register |
| ovf_flag | output | 1 | Overflow/underflow event flag |
| trig_flag | output | 1 | Trigger-edge event flag |
| baud_tick | output | 1 | One-cycle strobe at each baud-mode wrap |

## Verification
The bench targets several boundary cases, and each one points to a specific fault. A trigger reload that lands together with a count step at FFFFh would show a spurious overflow flag or a count one past the reload value. A down count that reaches the reload value must land on FFFFh; a design that compared against zero would wrap to the wrong value. A software flag clear that coincides with a hardware set must leave the flag set; otherwise the event would be lost. A baud-mode wrap must strobe once and leave the overflow flag alone, and pin edges must count only at mc_en samples; a design that got either wrong would show an extra flag or double counts.

// File: rtl/t2rc_pkg.sv
package t2rc_pkg;

  // control byte bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_EXT  = 1;
  localparam int CB_CAP  = 2;
  localparam int CB_TEN  = 3;
  localparam int CB_BAUD = 4;
  localparam int CB_OVF  = 5;
  localparam int CB_TRG  = 6;

  // mode byte bit positions
  localparam int MB_UPDN = 0;

  typedef struct packed {
    logic updown;
    logic baud_sel;
    logic trig_en;
    logic cap_sel;
    logic ext_sel;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/t2rc_edge.sv
module t2rc_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_en,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);

  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst)         prev <= '0;
    else if (smp_en) prev <= pin;
  end

  // a falling edge is seen at a sampling cycle: old sample high, new low
  for (genvar i = 0; i < N; i++) begin : g_fall
    assign fall[i] = smp_en & prev[i] & ~pin[i];
  end

endmodule

// File: rtl/t2rc_regs.sv
module t2rc_regs
  import t2rc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [CNT_W/DATA_W-1:0]   cnt_we,
  output logic [CNT_W/DATA_W-1:0]   rld_we,
  output logic                      ctl_we,
  output ctrl_t                     ctrl
);

  localparam int NB = CNT_W / DATA_W;
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(2 * NB);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(2 * NB + 1);

  logic mode_we;

  for (genvar b = 0; b < NB; b++) begin : g_dec
    assign cnt_we[b] = wr_en && (wr_addr == ADDR_W'(b));
    assign rld_we[b] = wr_en && (wr_addr == ADDR_W'(NB + b));
  end

  assign ctl_we  = wr_en && (wr_addr == A_CTL);
  assign mode_we = wr_en && (wr_addr == A_MODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else begin
      if (ctl_we) begin
        ctrl.run      <= wr_data[CB_RUN];
        ctrl.ext_sel  <= wr_data[CB_EXT];
        ctrl.cap_sel  <= wr_data[CB_CAP];
        ctrl.trig_en  <= wr_data[CB_TEN];
        ctrl.baud_sel <= wr_data[CB_BAUD];
      end
      if (mode_we) ctrl.updown <= wr_data[MB_UPDN];
    end
  end

  // flag bits of the control byte are consumed by the flag register
  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:CB_BAUD+1];

endmodule

// File: rtl/t2rc_flags.sv
module t2rc_flags (
  input  logic clk,
  input  logic rst,
  input  logic ctl_we,
  input  logic ovf_wval,
  input  logic trg_wval,
  input  logic ovf_evt,
  input  logic trg_evt,
  output logic ovf_flag,
  output logic trig_flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag  <= 1'b0;
      trig_flag <= 1'b0;
    end else begin
      if (ovf_evt)     ovf_flag  <= 1'b1;
      else if (ctl_we) ovf_flag  <= ovf_wval;
      if (trg_evt)     trig_flag <= 1'b1;
      else if (ctl_we) trig_flag <= trg_wval;
    end
  end

endmodule

// File: rtl/t2rc_core.sv
module t2rc_core
  import t2rc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctrl_t                   ctrl,
  input  logic                    mc_en,
  input  logic                    pin_fall,
  input  logic                    trig_fall,
  input  logic                    trig_lvl,
  input  logic [CNT_W/DATA_W-1:0] cnt_we,
  input  logic [CNT_W/DATA_W-1:0] rld_we,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [CNT_W-1:0]        cnt_q,
  output logic [CNT_W-1:0]        rld_q,
  output logic                    baud_tick,
  output logic                    ovf_evt,
  output logic                    trg_evt
);

  localparam int NB = CNT_W / DATA_W;
  localparam logic [CNT_W-1:0] ALL1 = '1;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             step, baud_m, cap_m, rl_m, dn_m, trig_hit, wrap;
  logic [CNT_W-1:0] cnt_hw, rld_hw;

  always_comb begin
    baud_m   = ctrl.baud_sel;
    cap_m    = !ctrl.baud_sel && ctrl.cap_sel;
    rl_m     = !ctrl.baud_sel && !ctrl.cap_sel;
    dn_m     = rl_m && ctrl.updown;
    step     = ctrl.run && (ctrl.ext_sel ? pin_fall : (baud_m ? 1'b1 : mc_en));
    trig_hit = trig_fall && ctrl.trig_en && !dn_m;
  end

  always_comb begin
    cnt_hw  = cnt_q;
    rld_hw  = rld_q;
    ovf_evt = 1'b0;
    wrap    = 1'b0;
    if (trig_hit && rl_m) begin
      cnt_hw = rld_q;
    end else if (step) begin
      if (dn_m && !trig_lvl) begin
        if (cnt_q == rld_q) begin
          cnt_hw  = ALL1;
          ovf_evt = 1'b1;
        end else begin
          cnt_hw = cnt_q - ONE;
        end
      end else if (cnt_q == ALL1) begin
        cnt_hw  = cap_m ? '0 : rld_q;
        ovf_evt = !baud_m;
        wrap    = baud_m;
      end else begin
        cnt_hw = cnt_q + ONE;
      end
    end
    if (trig_hit && cap_m) rld_hw = cnt_q;
    trg_evt = trig_hit;
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[b*DATA_W +: DATA_W] <= '0;
        rld_q[b*DATA_W +: DATA_W] <= '0;
      end else begin
        cnt_q[b*DATA_W +: DATA_W] <= cnt_we[b] ? wr_data : cnt_hw[b*DATA_W +: DATA_W];
        rld_q[b*DATA_W +: DATA_W] <= rld_we[b] ? wr_data : rld_hw[b*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) baud_tick <= 1'b0;
    else     baud_tick <= wrap;
  end

endmodule

// File: rtl/t2_reload_capture.sv
module t2_reload_capture
  import t2rc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mc_en,
  input  logic              ext_count_in,
  input  logic              trig_in,
  output logic [CNT_W-1:0]  count_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              ovf_flag,
  output logic              trig_flag,
  output logic              baud_tick
);

  localparam int NB = CNT_W / DATA_W;

  ctrl_t         ctrl;
  logic [NB-1:0] cnt_we, rld_we;
  logic          ctl_we;
  logic [1:0]    falls;
  logic          ovf_evt, trg_evt;

  t2rc_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_we(cnt_we), .rld_we(rld_we), .ctl_we(ctl_we), .ctrl(ctrl)
  );

  t2rc_edge #(.N(2)) u_edge (
    .clk(clk), .rst(rst), .smp_en(mc_en),
    .pin({trig_in, ext_count_in}), .fall(falls)
  );

  t2rc_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .ctrl(ctrl), .mc_en(mc_en),
    .pin_fall(falls[0]), .trig_fall(falls[1]), .trig_lvl(trig_in),
    .cnt_we(cnt_we), .rld_we(rld_we), .wr_data(wr_data),
    .cnt_q(count_q), .rld_q(reload_q), .baud_tick(baud_tick),
    .ovf_evt(ovf_evt), .trg_evt(trg_evt)
  );

  t2rc_flags u_flags (
    .clk(clk), .rst(rst), .ctl_we(ctl_we),
    .ovf_wval(wr_data[CB_OVF]), .trg_wval(wr_data[CB_TRG]),
    .ovf_evt(ovf_evt), .trg_evt(trg_evt),
    .ovf_flag(ovf_flag), .trig_flag(trig_flag)
  );

endmodule

// File: rtl/t2rc_chk.sv
module t2rc_chk
  import t2rc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NB    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             mc_en,
  input logic             ctl_we,
  input logic [NB-1:0]    cnt_we,
  input logic [NB-1:0]    rld_we,
  input ctrl_t            ctrl,
  input logic             trig_fall,
  input logic             trig_lvl,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] reload_q,
  input logic             ovf_flag,
  input logic             trig_flag,
  input logic             baud_tick
);

  localparam logic [CNT_W-1:0] ALL1 = '1;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl.run && !ctrl.ext_sel && !ctrl.baud_sel && !ctrl.cap_sel && !ctrl.updown &&
     mc_en && !(|cnt_we) && !trig_fall && count_q != ALL1)
    |=> count_q == $past(count_q) + ONE);

  p_halt_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run && !(|cnt_we) && !trig_fall) |=> $stable(count_q));

  p_trig_off_r7: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.trig_en && !ctl_we && !trig_flag) |=> !trig_flag);

  p_down_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl.run && ctrl.updown && !ctrl.cap_sel && !ctrl.baud_sel && !ctrl.ext_sel &&
     mc_en && !trig_lvl && count_q == reload_q && !(|cnt_we))
    |=> (count_q == ALL1) && ovf_flag);

  p_capture_r10: assert property (@(posedge clk) disable iff (rst)
    (ctrl.cap_sel && !ctrl.baud_sel && ctrl.trig_en && trig_fall && !(|rld_we))
    |=> reload_q == $past(count_q));

  p_baud_noflag_r11: assert property (@(posedge clk) disable iff (rst)
    (ctrl.baud_sel && !ctl_we && !ovf_flag) |=> !ovf_flag);

  p_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> $past(ctrl.baud_sel && ctrl.run && count_q == ALL1));

endmodule

bind t2_reload_capture t2rc_chk #(.CNT_W(CNT_W), .NB(CNT_W / DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mc_en(mc_en), .ctl_we(ctl_we),
  .cnt_we(cnt_we), .rld_we(rld_we), .ctrl(ctrl),
  .trig_fall(falls[1]), .trig_lvl(trig_in),
  .count_q(count_q), .reload_q(reload_q),
  .ovf_flag(ovf_flag), .trig_flag(trig_flag), .baud_tick(baud_tick)
);

// File: tb/sim_t2_reload_capture.sv
module sim_t2_reload_capture;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        mc_en;
  logic        ext_count_in;
  logic        trig_in;
  logic [15:0] count_q, reload_q;
  logic        ovf_flag, trig_flag, baud_tick;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference state
  logic [15:0] m_cnt, m_rld;
  logic m_ovf, m_exf, m_bt, m_pd, m_td;
  logic m_run, m_ext, m_cap, m_ten, m_baud, m_ud;

  always #4 clk = ~clk;

  t2_reload_capture u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mc_en(mc_en), .ext_count_in(ext_count_in), .trig_in(trig_in),
    .count_q(count_q), .reload_q(reload_q), .ovf_flag(ovf_flag),
    .trig_flag(trig_flag), .baud_tick(baud_tick)
  );

  task automatic model_reset();
    m_cnt = 0; m_rld = 0; m_ovf = 0; m_exf = 0; m_bt = 0; m_pd = 0; m_td = 0;
    m_run = 0; m_ext = 0; m_cap = 0; m_ten = 0; m_baud = 0; m_ud = 0;
  endtask

  // one state-clock step of the expected behaviour, from the requirements
  task automatic model_step();
    logic pf, tf, stp, hit, so, se, bt, updn_mode;
    logic [15:0] nc, nr;
    pf  = mc_en && m_pd && !ext_count_in;
    tf  = mc_en && m_td && !trig_in;
    stp = m_run && (m_ext ? pf : (m_baud ? 1'b1 : mc_en));
    updn_mode = !m_baud && !m_cap && m_ud;
    hit = tf && m_ten && !updn_mode;
    nc = m_cnt; nr = m_rld; so = 0; bt = 0; se = hit;
    if (hit && !m_baud && !m_cap) nc = m_rld;              // R7
    else if (stp) begin
      if (updn_mode && !trig_in) begin                      // R8 down
        if (m_cnt == m_rld) begin nc = 16'hFFFF; so = 1; end
        else nc = m_cnt - 16'd1;
      end else if (m_cnt == 16'hFFFF) begin
        if (m_baud) begin nc = m_rld; bt = 1; end          // R11
        else if (m_cap) begin nc = 16'h0000; so = 1; end   // R10
        else begin nc = m_rld; so = 1; end                 // R6
      end else nc = m_cnt + 16'd1;
    end
    if (hit && m_cap && !m_baud) nr = m_cnt;               // R10
    if (wr_en) begin
      case (wr_addr)
        3'd0: nc[7:0]  = wr_data;
        3'd1: nc[15:8] = wr_data;
        3'd2: nr[7:0]  = wr_data;
        3'd3: nr[15:8] = wr_data;
        default: ;
      endcase
    end
    m_ovf = so ? 1'b1 : ((wr_en && wr_addr == 3'd4) ? wr_data[5] : m_ovf);
    m_exf = se ? 1'b1 : ((wr_en && wr_addr == 3'd4) ? wr_data[6] : m_exf);
    if (wr_en && wr_addr == 3'd4) begin
      m_run = wr_data[0]; m_ext = wr_data[1]; m_cap = wr_data[2];
      m_ten = wr_data[3]; m_baud = wr_data[4];
    end
    if (wr_en && wr_addr == 3'd5) m_ud = wr_data[0];
    if (mc_en) begin m_pd = ext_count_in; m_td = trig_in; end
    m_cnt = nc; m_rld = nr; m_bt = bt;
  endtask

  task automatic cyc(input logic we, input logic [2:0] a, input logic [7:0] d,
                     input logic mc, input logic pin, input logic trg);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; mc_en = mc; ext_count_in = pin; trig_in = trg;
    @(posedge clk);
    model_step();
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, ext_count_in, trig_in);
  endtask

  task automatic tk(input logic mc, input logic pin, input logic trg);
    cyc(1'b0, 3'd0, 8'h00, mc, pin, trg);
  endtask

  task automatic cmp(input string tag);
    checks++;
    if (count_q !== m_cnt || reload_q !== m_rld || ovf_flag !== m_ovf ||
        trig_flag !== m_exf || baud_tick !== m_bt) begin
      errors++;
      $display("FAIL %s: actual cnt=%h rld=%h ovf=%b trg=%b bt=%b expected cnt=%h rld=%h ovf=%b trg=%b bt=%b",
               tag, count_q, reload_q, ovf_flag, trig_flag, baud_tick,
               m_cnt, m_rld, m_ovf, m_exf, m_bt);
    end
  endtask

  task automatic exp16(input string tag, input logic [15:0] act, input logic [15:0] ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, ex);
    end
  endtask

  task automatic exp1(input string tag, input logic act, input logic ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, ex);
    end
  endtask

  function automatic string mtag();
    if (m_baud) return "R11";
    if (m_cap)  return "R10";
    if (m_ud)   return "R8";
    return "R6";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd20240611);
    rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; mc_en = 0;
    ext_count_in = 1'b1; trig_in = 1'b1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #6;
    // R1 reset state
    cmp("R1"); exp16("R1 count", count_q, 16'h0000); exp1("R1 tick", baud_tick, 1'b0);

    // R2 byte writes
    wr(3'd0, 8'h34); wr(3'd1, 8'h12); wr(3'd2, 8'hCD); wr(3'd3, 8'hAB);
    exp16("R2 count", count_q, 16'h1234); exp16("R2 reload", reload_q, 16'hABCD);

    // R3 timer function
    wr(3'd4, 8'h01);
    tk(1, 1, 1); tk(0, 1, 1); tk(1, 1, 1); tk(1, 1, 1); tk(0, 1, 1);
    exp16("R3", count_q, 16'h1237); cmp("R3");

    // R5 stopped
    wr(3'd4, 8'h00);
    repeat (4) tk(1, 1, 1);
    exp16("R5", count_q, 16'h1237);

    // R4 external pin edges
    wr(3'd4, 8'h03);
    tk(1, 0, 1); tk(1, 0, 1); tk(0, 1, 1); tk(1, 1, 1); tk(0, 0, 1); tk(1, 0, 1);
    exp16("R4", count_q, 16'h1239); cmp("R4");

    // R6 reload on overflow
    wr(3'd4, 8'h00); wr(3'd0, 8'hFE); wr(3'd1, 8'hFF); wr(3'd2, 8'h00); wr(3'd3, 8'h80);
    wr(3'd4, 8'h01);
    tk(1, 0, 1); tk(1, 0, 1);
    exp16("R6", count_q, 16'h8000); exp1("R6 flag", ovf_flag, 1'b1);

    // R12 software clear, then clear colliding with a hardware set
    wr(3'd4, 8'h01);
    exp1("R12 clear", ovf_flag, 1'b0);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    cyc(1'b1, 3'd4, 8'h01, 1'b1, 1'b0, 1'b1);
    exp1("R12 hw wins", ovf_flag, 1'b1); cmp("R12");

    // R7 trigger reload, then disabled trigger
    wr(3'd4, 8'h09); wr(3'd0, 8'h55);
    tk(1, 0, 0);
    exp16("R7 reload", count_q, 16'h8000); exp1("R7 flag", trig_flag, 1'b1);
    wr(3'd4, 8'h01);
    tk(1, 0, 1); tk(1, 0, 0);
    exp16("R7 ignored", count_q, 16'h8002); exp1("R7 no flag", trig_flag, 1'b0);

    // R8 up/down
    wr(3'd5, 8'h01); wr(3'd4, 8'h01);
    tk(1, 0, 0); tk(1, 0, 0); tk(1, 0, 0);
    exp16("R8 down", count_q, 16'hFFFF); exp1("R8 flag", ovf_flag, 1'b1);
    wr(3'd4, 8'h01);
    tk(1, 0, 1);
    exp16("R8 up", count_q, 16'h8000); exp1("R8 up flag", ovf_flag, 1'b1);

    // R9 trigger edge ignored in up/down mode
    wr(3'd4, 8'h09);
    tk(1, 0, 0);
    exp16("R9 count", count_q, 16'hFFFF); exp1("R9 flag", trig_flag, 1'b0);
    wr(3'd5, 8'h00);

    // R10 capture
    wr(3'd4, 8'h0D);
    tk(1, 0, 1);
    exp16("R10 wrap", count_q, 16'h0000); exp1("R10 ovf", ovf_flag, 1'b1);
    tk(1, 0, 1); tk(1, 0, 0);
    exp16("R10 capture", reload_q, 16'h0001); exp16("R10 count", count_q, 16'h0002);
    exp1("R10 flag", trig_flag, 1'b1);

    // R11 baud mode
    wr(3'd4, 8'h00); wr(3'd0, 8'hFD); wr(3'd1, 8'hFF); wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    wr(3'd4, 8'h19);
    tk(0, 0, 0); tk(0, 0, 0); tk(0, 0, 0);
    exp16("R11 reload", count_q, 16'h1234); exp1("R11 strobe", baud_tick, 1'b1);
    exp1("R11 no ovf", ovf_flag, 1'b0);
    tk(0, 0, 0);
    exp1("R11 strobe end", baud_tick, 1'b0); exp16("R11 count", count_q, 16'h1235);
    tk(1, 0, 1); tk(1, 0, 0);
    exp1("R11 trig flag", trig_flag, 1'b1); exp16("R11 no capture", reload_q, 16'h1234);
    exp16("R11 no load", count_q, 16'h1237);

    // R12 software set
    wr(3'd4, 8'h20);
    exp1("R12 set", ovf_flag, 1'b1); exp1("R12 trig clr", trig_flag, 1'b0);

    // constrained random against the reference
    for (int seg = 0; seg < 60; seg++) begin
      wr(3'd5, 8'($urandom % 2));
      wr(3'd4, 8'(($urandom & 32'h1F) | ((seg % 5 != 0) ? 1 : 0)));
      if ($urandom % 2 == 0) wr(3'd1, 8'hFF);
      if ($urandom % 3 == 0) wr(3'd0, 8'($urandom % 256) | 8'hF0);
      for (int k = 0; k < 50; k++) begin
        logic we, mc, pn, tg;
        logic [2:0] a;
        logic [7:0] d;
        we = ($urandom % 20 == 0);
        a  = 3'($urandom % 6);
        d  = 8'($urandom % 256);
        mc = ($urandom % 3 == 0);
        pn = ($urandom % 4 == 0) ? ~ext_count_in : ext_count_in;
        tg = ($urandom % 4 == 0) ? ~trig_in : trig_in;
        cyc(we, a, d, mc, pn, tg);
        cmp(mtag());
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule